// File: doc/BRIEF.md
# Single-Bit and Address-Generation Unit

This block performs two families of 64-bit integer operations. The first family works on one bit of an operand at an index: it can force that bit high, force it low, flip it, or return it as the whole result. The index comes from a 6-bit immediate or from the low six bits of the second operand. The second family builds addresses. It shifts the first operand left by one, two or three places and adds the second operand. It can also zero-extend the low word of the first operand before that shift, add a zero-extended word, or place the zero-extended low word at a bit position taken from the index.

The arithmetic and the mask logic are combinational. The result is held in one output register behind a valid/ready pair. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds, and so does input acceptance.

Top module: `bitaddr_unit`

## Requirements
- R1: An operation accepted at a clock edge appears on `out_result` with `out_valid` high after that edge. Results leave in the order they were accepted, each exactly once. `in_ready` is high whenever the output register is empty or `out_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` does not change at the next edge.
- R3: While `rst_n` is low, and at the first edge after its release, `out_valid` is low.
- R4: The bit index is `in_imm` when `in_use_imm` is 1, and `in_b[5:0]` otherwise. Bits 63:6 of `in_b` never affect the single-bit operations or the zero-extended-word shift.
- R5: Op 0 returns `in_a` with bit index set. Op 1 returns `in_a` with that bit cleared. Op 2 returns `in_a` with that bit inverted.
- R6: Op 3 returns bit index of `in_a` in bit 0, and zero in bits 63:1.
- R7: Ops 4, 5 and 6 return `(in_a << n) + in_b` for n = 1, 2 and 3.
- R8: Ops 7, 8 and 9 return `({32'b0, in_a[31:0]} << n) + in_b` for n = 1, 2 and 3.
- R9: Op 10 returns `{32'b0, in_a[31:0]} + in_b`.
- R10: Op 11 returns `{32'b0, in_a[31:0]} << index`. Bits shifted past 63 are lost, and every other bit is zero.
- R11: All sums wrap modulo 2^64, and no carry is reported.
- R12: Op codes 12 to 15 return a zero result, but still complete the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take the offered operation |
| in_op | input | 4 | Operation code (see requirements) |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand, or the index source in its low six bits |
| in_imm | input | 6 | Immediate bit index or shift amount |
| in_use_imm | input | 1 | 1 selects `in_imm` as the index |
| out_valid | output | 1 | `out_result` holds a result |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 64 | Result of the operation |

## Verification
Two things can happen in the same cycle: a held result can drain and a new operation can be accepted. The bench provokes this by toggling `out_ready` at random while it keeps offering operations. It judges the outcome with an in-order queue of expected results, so a lost, repeated or early result shows up as a mismatch. When downstream stalls, the bench also checks that the held result stays fixed until it is taken.

// File: rtl/bau_pkg.sv
package bau_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned WORD   = 32;
  localparam int unsigned IDXW   = $clog2(XLEN);
  localparam int unsigned OPW    = 4;
  localparam int unsigned MAX_SH = 3;

  typedef enum logic [OPW-1:0] {
    OP_SET_BIT     = 4'd0,
    OP_CLR_BIT     = 4'd1,
    OP_FLIP_BIT    = 4'd2,
    OP_GET_BIT     = 4'd3,
    OP_SHL1_ADD    = 4'd4,
    OP_SHL2_ADD    = 4'd5,
    OP_SHL3_ADD    = 4'd6,
    OP_SHL1_ADD_ZW = 4'd7,
    OP_SHL2_ADD_ZW = 4'd8,
    OP_SHL3_ADD_ZW = 4'd9,
    OP_ADD_ZW      = 4'd10,
    OP_SHL_ZW      = 4'd11,
    OP_RSV12       = 4'd12,
    OP_RSV13       = 4'd13,
    OP_RSV14       = 4'd14,
    OP_RSV15       = 4'd15
  } bau_op_e;
endpackage

// File: rtl/bau_bit_ops.sv
module bau_bit_ops
  import bau_pkg::*;
(
  input  bau_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [IDXW-1:0] idx,
  output logic            hit,
  output logic [XLEN-1:0] result
);
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] moved;

  assign mask  = {{(XLEN-1){1'b0}}, 1'b1} << idx;
  assign moved = a >> idx;

  always_comb begin
    hit    = 1'b1;
    result = '0;
    unique case (op)
      OP_SET_BIT:  result = a | mask;
      OP_CLR_BIT:  result = a & ~mask;
      OP_FLIP_BIT: result = a ^ mask;
      OP_GET_BIT:  result = {{(XLEN-1){1'b0}}, moved[0]};
      default:     hit    = 1'b0;
    endcase
  end
endmodule

// File: rtl/bau_addr_gen.sv
module bau_addr_gen
  import bau_pkg::*;
(
  input  bau_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [IDXW-1:0] idx,
  output logic            hit,
  output logic [XLEN-1:0] result
);
  logic [XLEN-1:0] a_zw;
  logic [XLEN-1:0] sum_full [1:MAX_SH];
  logic [XLEN-1:0] sum_zw   [1:MAX_SH];

  assign a_zw = {{(XLEN-WORD){1'b0}}, a[WORD-1:0]};

  for (genvar n = 1; n <= MAX_SH; n++) begin : g_shadd
    assign sum_full[n] = (a    << n) + b;
    assign sum_zw[n]   = (a_zw << n) + b;
  end

  always_comb begin
    hit    = 1'b1;
    result = '0;
    unique case (op)
      OP_SHL1_ADD:    result = sum_full[1];
      OP_SHL2_ADD:    result = sum_full[2];
      OP_SHL3_ADD:    result = sum_full[3];
      OP_SHL1_ADD_ZW: result = sum_zw[1];
      OP_SHL2_ADD_ZW: result = sum_zw[2];
      OP_SHL3_ADD_ZW: result = sum_zw[3];
      OP_ADD_ZW:      result = a_zw + b;
      OP_SHL_ZW:      result = a_zw << idx;
      default:        hit    = 1'b0;
    endcase
  end
endmodule

// File: rtl/bau_out_stage.sv
module bau_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R2: a stalled result keeps its value and its valid flag
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R1: an accepted item is presented after the edge
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/bitaddr_unit.sv
module bitaddr_unit
  import bau_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OPW-1:0]  in_op,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic [IDXW-1:0] in_imm,
  input  logic            in_use_imm,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result
);
  localparam int unsigned PW = OPW + IDXW + XLEN;

  bau_op_e         op;
  logic [IDXW-1:0] idx;
  logic            bit_hit, addr_hit;
  logic [XLEN-1:0] bit_res, addr_res, res;
  logic [PW-1:0]   pay_in, pay_out;
  bau_op_e         op_q;
  logic [IDXW-1:0] idx_q;

  assign op  = bau_op_e'(in_op);
  assign idx = in_use_imm ? in_imm : in_b[IDXW-1:0];

  bau_bit_ops u_bit (
    .op     (op),
    .a      (in_a),
    .idx    (idx),
    .hit    (bit_hit),
    .result (bit_res)
  );

  bau_addr_gen u_addr (
    .op     (op),
    .a      (in_a),
    .b      (in_b),
    .idx    (idx),
    .hit    (addr_hit),
    .result (addr_res)
  );

  always_comb begin
    if (bit_hit)       res = bit_res;
    else if (addr_hit) res = addr_res;
    else               res = '0;
  end

  assign pay_in = {in_op, idx, res};

  bau_out_stage #(.W(PW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign op_q       = bau_op_e'(pay_out[PW-1 -: OPW]);
  assign idx_q      = pay_out[XLEN +: IDXW];
  assign out_result = pay_out[XLEN-1:0];

  // R5: the chosen bit is high after a set and low after a clear
  p_set_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q == OP_SET_BIT |-> out_result[idx_q]);
  p_clr_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q == OP_CLR_BIT |-> !out_result[idx_q]);

  // R6: an extracted bit leaves only bit 0 possibly high
  p_get_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q == OP_GET_BIT |-> out_result[XLEN-1:1] == '0);

  // R10: bits below the placement position are zero
  p_shl_zw_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q == OP_SHL_ZW |->
      (out_result & (({{(XLEN-1){1'b0}}, 1'b1} << idx_q) - 1'b1)) == '0);

  // R12: reserved codes produce zero
  p_rsv_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q[OPW-1:OPW-2] == 2'b11 |-> out_result == '0);
endmodule

// File: tb/bitaddr_unit_tb.sv
module bitaddr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [3:0]  in_op;
  logic [63:0] in_a, in_b;
  logic [5:0]  in_imm;
  logic        in_use_imm;
  logic        out_valid, out_ready;
  logic [63:0] out_result;

  always #5 clk = ~clk;

  bitaddr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .in_use_imm(in_use_imm), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result)
  );

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q[$];
  logic [3:0]  opc_q[$];

  function automatic logic [63:0] model(logic [3:0] op, logic [63:0] a,
      logic [63:0] b, logic [5:0] imm, logic use_imm);
    logic [5:0]  k;
    logic [63:0] one, zw;
    k   = use_imm ? imm : b[5:0];          // R4 index source
    one = 64'd1 << k;
    zw  = {32'd0, a[31:0]};
    case (op)
      4'd0:  return a | one;
      4'd1:  return a & ~one;
      4'd2:  return a ^ one;
      4'd3:  return {63'd0, a[k]};
      4'd4:  return (a << 1) + b;          // R11 wraps naturally in 64 bits
      4'd5:  return (a << 2) + b;
      4'd6:  return (a << 3) + b;
      4'd7:  return (zw << 1) + b;
      4'd8:  return (zw << 2) + b;
      4'd9:  return (zw << 3) + b;
      4'd10: return zw + b;
      4'd11: return zw << k;
      default: return 64'd0;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] op);
    if (op <= 4'd2) return "R5";
    if (op == 4'd3) return "R6";
    if (op <= 4'd6) return "R7";
    if (op <= 4'd9) return "R8";
    if (op == 4'd10) return "R9";
    if (op == 4'd11) return "R10";
    return "R12";
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pick_directed(input int n);
    in_use_imm = 1'b0; in_imm = 6'd0; in_b = 64'd0;
    case (n)
      0: begin in_op = 4'd0; in_a = 64'd0; in_imm = 6'd63; in_use_imm = 1'b1;
               in_b = 64'hFFFF_FFFF_FFFF_FF80; end                       // R4
      1: begin in_op = 4'd1; in_a = '1; in_b = 64'hFFFF_FFFF_FFFF_FFC0; end // R4
      2: begin in_op = 4'd2; in_a = 64'h5; in_b = 64'h2; end
      3: begin in_op = 4'd3; in_a = 64'h8000_0000_0000_0000; in_imm = 6'd63;
               in_use_imm = 1'b1; end
      4: begin in_op = 4'd6; in_a = '1; in_b = 64'd8; end                 // R11 wrap to 0
      5: begin in_op = 4'd7; in_a = 64'hFFFF_FFFF_8000_0000; end
      6: begin in_op = 4'd10; in_a = 64'hDEAD_0000_FFFF_FFFF; in_b = 64'd1; end
      7: begin in_op = 4'd11; in_a = '1; in_imm = 6'd40; in_use_imm = 1'b1; end
      8: begin in_op = 4'd13; in_a = '1; in_b = '1; end
      9: begin in_op = 4'd8; in_a = 64'h1234_5678_0000_0003; in_b = 64'd1; end
      10: begin in_op = 4'd11; in_a = 64'h1; in_b = 64'hABCD_0000_0000_003F; end
      default: begin in_op = 4'd3; in_a = 64'h2; in_b = 64'h1; end
    endcase
  endtask

  localparam int NDIR   = 12;
  localparam int NCYC   = 4000;
  localparam int NDRAIN = 20;

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int          issued;
    bit          pending;
    bit          hold_prev;
    logic [63:0] held;
    logic [63:0] e;
    logic [3:0]  eop;
    void'($urandom(32'd24680));
    issued = 0; pending = 1'b0; hold_prev = 1'b0; held = '0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_op = '0; in_a = '0; in_b = '0; in_imm = '0; in_use_imm = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R3", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R3", {63'd0, out_valid}, 64'd0);

    for (int cyc = 0; cyc < NCYC + NDRAIN; cyc++) begin
      @(negedge clk);
      if (hold_prev)
        check(out_valid && out_result == held, "R2", out_result, held);
      if (!pending) begin
        if (cyc < NCYC && (issued < NDIR || ($urandom % 5) != 0)) begin
          if (issued < NDIR) pick_directed(issued);
          else begin
            in_op      = 4'($urandom % 16);
            in_a       = {$urandom, $urandom};
            in_b       = {$urandom, $urandom};
            in_imm     = 6'($urandom);
            in_use_imm = 1'($urandom);
          end
          in_valid = 1'b1;
          pending  = 1'b1;
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = (cyc >= NCYC) ? 1'b1 : (($urandom % 4) != 0);
      #1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", out_result, 64'd0);
        end else begin
          e   = exp_q.pop_front();
          eop = opc_q.pop_front();
          check(out_result === e, req_of(eop), out_result, e);
        end
      end
      hold_prev = out_valid && !out_ready;
      held      = out_result;
      check(in_ready == (!out_valid || out_ready), "R1",
            {63'd0, in_ready}, {63'd0, (!out_valid || out_ready)});
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_op, in_a, in_b, in_imm, in_use_imm));
        opc_q.push_back(in_op);
        issued++;
        pending = 1'b0;
      end
    end
    in_valid = 1'b0;
    check(exp_q.size() == 0, "R1", 64'(exp_q.size()), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule